// File: doc/BRIEF.md
# Store-Load Address Disambiguation Queue

This block sits between one store and one load of a dataflow circuit that may touch the same memory word. The store side pushes its address as soon as that address is computed, even if the data to be written is still on its way. Each load address is compared with every store address still held. A load with no match passes straight on, ahead of older stores whose data has not yet reached memory. A load with a match waits until that store's address has left the queue. Each completed store write is reported with a one-cycle pulse, and that pulse removes the oldest held address.

Two internal tokens keep the store and the load in program order. A store address may enter only after the previous load has passed its check. A load may be checked only after the store before it has entered the queue. A store entering in the same cycle hands its token to the load at once, and its address joins the comparison in that same cycle.

Top module: `addr_disamb_q`

## Requirements
- R1: `enq_ready` is low whenever DEPTH addresses are held. An address is taken only in a cycle where `enq_valid` and `enq_ready` are both high.
- R2: After reset the queue is empty, `enq_ready` is high (the store token is present), `pass_valid` and `chk_ready` are low (no load token) and `underflow_err` is low.
- R3: A load address that holds the load token and matches no held store address appears on `pass_addr` with `pass_valid` high in the same cycle. It is taken when `pass_ready` is high, and `chk_ready` follows `pass_ready`.
- R4: A load address equal to any held store address keeps `pass_valid` and `chk_ready` low until every held copy of that address has been removed.
- R5: A store address taken in a cycle gives the load its token in that same cycle, and it counts as a conflict when it equals `chk_addr`.
- R6: In the cycle a `store_done` pulse removes the head address, that head still counts as a conflict.
- R7: Taking a store address clears the store token. Passing a load sets the store token again and clears the load token. Without the load token a load is held, and without the store token `enq_ready` is low.
- R8: A `store_done` pulse while the queue is empty changes no held state and sets `underflow_err`. The flag then stays high until reset.
- R9: Each `store_done` pulse on a non-empty queue removes the oldest held address, so addresses leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Store address offered |
| enq_addr | input | AW | Store address |
| enq_ready | output | 1 | Store address can be taken (space and store token) |
| chk_valid | input | 1 | Load address offered for checking |
| chk_addr | input | AW | Load address |
| chk_ready | output | 1 | Load address is taken this cycle when valid |
| pass_valid | output | 1 | Load address cleared to go downstream |
| pass_addr | output | AW | Cleared load address |
| pass_ready | input | 1 | Downstream accepts the cleared load address |
| store_done | input | 1 | One-cycle pulse: a store's write has completed |
| underflow_err | output | 1 | Sticky: a completion arrived with the queue empty |

## Verification
The interesting collisions are a load check that falls in the same cycle as a store enqueue, and a load check that falls in the same cycle as a completion pulse. Directed steps set up both. An equal address enqueued with a load must hold the load. A load equal to the head must be held while that head is being removed and must pass in the cycle after. A long pseudo-random phase then drives the enqueue, the check and the completion pulse together over a four-value address space, so matches happen often. In every cycle the bench compares the handshakes with a queue model built from the requirements.

// File: rtl/adq_pkg.sv
package adq_pkg;

    // Events fired by the top in one cycle
    typedef struct packed {
        logic enq;   // store address accepted
        logic ld;    // load address passed downstream
        logic pop;   // completion removes head
        logic bad;   // completion seen on empty queue
    } adq_ev_t;

    function automatic int ptr_w(input int d);
        return (d > 1) ? $clog2(d) : 1;
    endfunction

    function automatic logic [31:0] ring_next(input logic [31:0] p, input int d);
        return (p == 32'(d - 1)) ? 32'd0 : p + 32'd1;
    endfunction

endpackage

// File: rtl/adq_store.sv
module adq_store
    import adq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = ptr_w(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    input  logic [AW-1:0] probe_addr,
    output logic          hit,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] cnt
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [PW-1:0]    head_q, tail_q;
    logic [CW-1:0]    cnt_q;
    logic [DEPTH-1:0] hv;

    // one comparator per slot, valid slots only
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hv[i] = vld_q[i] && (addr_q[i] == probe_addr);
    end

    assign hit   = |hv;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign cnt   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            vld_q  <= '0;
        end else begin
            if (push) begin
                addr_q[tail_q] <= push_addr;
                vld_q[tail_q]  <= 1'b1;
                tail_q         <= PW'(ring_next(32'(tail_q), DEPTH));
            end
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= PW'(ring_next(32'(head_q), DEPTH));
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/adq_order.sv
module adq_order (
    input  logic clk,
    input  logic rst,
    input  logic enq_fire,
    input  logic ld_fire,
    output logic st_gate,
    output logic ld_tok
);
    logic gate_q, tok_q;

    assign st_gate = gate_q;
    assign ld_tok  = tok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b1;
            tok_q  <= 1'b0;
        end else begin
            gate_q <= (gate_q & ~enq_fire) | ld_fire;
            tok_q  <= (tok_q | enq_fire) & ~ld_fire;
        end
    end
endmodule

// File: rtl/addr_disamb_q.sv
module addr_disamb_q
    import adq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_valid,
    input  logic [AW-1:0] enq_addr,
    output logic          enq_ready,
    input  logic          chk_valid,
    input  logic [AW-1:0] chk_addr,
    output logic          chk_ready,
    output logic          pass_valid,
    output logic [AW-1:0] pass_addr,
    input  logic          pass_ready,
    input  logic          store_done,
    output logic          underflow_err
);
    localparam int CW = $clog2(DEPTH + 1);

    adq_ev_t       ev;
    logic          q_hit, q_full, q_empty;
    logic [CW-1:0] q_cnt;
    logic          st_gate, ld_tok, tok_now;
    logic          conflict, ld_ok;
    logic          err_q;

    assign enq_ready = st_gate & ~q_full;
    assign ev.enq    = enq_valid & enq_ready;
    // same-cycle bypass: a store entering now is compared too
    assign conflict  = q_hit | (ev.enq & (enq_addr == chk_addr));
    assign tok_now   = ld_tok | ev.enq;
    assign ld_ok     = tok_now & ~conflict;

    assign pass_valid = chk_valid & ld_ok;
    assign pass_addr  = chk_addr;
    assign chk_ready  = pass_ready & ld_ok;
    assign ev.ld      = chk_valid & chk_ready;
    assign ev.pop     = store_done & ~q_empty;
    assign ev.bad     = store_done & q_empty;

    adq_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (ev.enq),
        .push_addr  (enq_addr),
        .pop        (ev.pop),
        .probe_addr (chk_addr),
        .hit        (q_hit),
        .full       (q_full),
        .empty      (q_empty),
        .cnt        (q_cnt)
    );

    adq_order u_order (
        .clk      (clk),
        .rst      (rst),
        .enq_fire (ev.enq),
        .ld_fire  (ev.ld),
        .st_gate  (st_gate),
        .ld_tok   (ld_tok)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else if (ev.bad) err_q <= 1'b1;
    end
    assign underflow_err = err_q;
endmodule

// File: rtl/adq_chk.sv
module adq_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          enq_fire,
    input logic          ld_fire,
    input logic          enq_ready,
    input logic [AW-1:0] enq_addr,
    input logic [AW-1:0] chk_addr,
    input logic          pass_valid,
    input logic          store_done,
    input logic          underflow_err,
    input logic [CW-1:0] cnt
);
    p_full_stall_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(DEPTH)) |-> !enq_ready);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> !(enq_fire && (enq_addr == chk_addr)));

    p_gate_close_r7: assert property (@(posedge clk) disable iff (rst)
        (enq_fire && !ld_fire) |=> !enq_ready);

    p_tok_spent_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_fire && !enq_fire) |=> (!pass_valid || enq_fire));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        underflow_err |=> underflow_err);

    p_empty_deq_r8: assert property (@(posedge clk) disable iff (rst)
        (store_done && cnt == '0) |=> underflow_err);

    p_pop_cnt_r9: assert property (@(posedge clk) disable iff (rst)
        (store_done && cnt != '0 && !enq_fire) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

bind addr_disamb_q adq_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enq_fire      (ev.enq),
    .ld_fire       (ev.ld),
    .enq_ready     (enq_ready),
    .enq_addr      (enq_addr),
    .chk_addr      (chk_addr),
    .pass_valid    (pass_valid),
    .store_done    (store_done),
    .underflow_err (underflow_err),
    .cnt           (q_cnt)
);

// File: tb/sim_addr_disamb_q.sv
module sim_addr_disamb_q;
    localparam int AW    = 4;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [AW-1:0] enq_addr = '0;
    logic          enq_ready;
    logic          chk_valid = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic          chk_ready;
    logic          pass_valid;
    logic [AW-1:0] pass_addr;
    logic          pass_ready = 1'b0;
    logic          store_done = 1'b0;
    logic          underflow_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [AW-1:0] mq[$];
    bit m_gate = 1'b1;
    bit m_tok  = 1'b0;
    bit m_err  = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    addr_disamb_q #(.AW(AW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_ready(enq_ready),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_ready(chk_ready),
        .pass_valid(pass_valid), .pass_addr(pass_addr), .pass_ready(pass_ready),
        .store_done(store_done), .underflow_err(underflow_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit ev, input logic [AW-1:0] ea,
                        input bit lv, input logic [AW-1:0] la,
                        input bit pr, input bit dq);
        bit e_rdy, e_fire, tok, hit, e_pv, e_cr, l_fire;
        @(negedge clk);
        enq_valid = ev; enq_addr = ea; chk_valid = lv; chk_addr = la;
        pass_ready = pr; store_done = dq;
        #1;
        e_rdy  = m_gate && (mq.size() < DEPTH);
        e_fire = ev && e_rdy;
        tok    = m_tok || e_fire;
        hit    = e_fire && (ea == la);
        foreach (mq[i]) if (mq[i] == la) hit = 1'b1;
        e_pv   = lv && tok && !hit;
        e_cr   = pr && tok && !hit;
        l_fire = lv && e_cr;
        chk(tag, "enq_ready", 32'(enq_ready), 32'(e_rdy));
        chk(tag, "pass_valid", 32'(pass_valid), 32'(e_pv));
        chk(tag, "chk_ready", 32'(chk_ready), 32'(e_cr));
        chk(tag, "underflow_err", 32'(underflow_err), 32'(m_err));
        if (e_pv) chk(tag, "pass_addr", 32'(pass_addr), 32'(la));
        @(posedge clk);
        if (dq) begin
            if (mq.size() == 0) m_err = 1'b1;
            else void'(mq.pop_front());
        end
        if (e_fire) mq.push_back(ea);
        m_gate = (m_gate && !e_fire) || l_fire;
        m_tok  = (m_tok || e_fire) && !l_fire;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired, R7 ordering stall suspected");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2: reset state, load offered but no token
        step("R2", 0, 0, 1, 3, 1, 0);
        // R8: completion on empty queue, then flag sticky, state untouched
        step("R8", 0, 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 0, 0);
        // R5: equal address enqueued with the load blocks it
        step("R5", 1, 3, 1, 3, 1, 0);
        // sweep every load address against queue {3}, not consumed
        for (int a = 0; a < 16; a++)
            step((a == 3) ? "R4" : "R3", 0, 0, 1, AW'(a), 0, 0);
        step("R3", 0, 0, 1, 5, 1, 0);
        // R7: no load token left
        step("R7", 0, 0, 1, 6, 1, 0);
        // R5: token handed over in the enqueue cycle
        step("R5", 1, 7, 1, 1, 1, 0);
        step("R7", 1, 3, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 2, 1, 0);
        step("R1", 1, 9, 0, 0, 0, 0);
        for (int a = 0; a < 16; a++)
            step((a == 3 || a == 7 || a == 9) ? "R4" : "R3", 0, 0, 1, AW'(a), 0, 0);
        step("R3", 0, 0, 1, 4, 1, 0);
        // R1: store token present but queue full
        step("R1", 1, 10, 0, 0, 0, 0);
        // R9: first pop removes the older 3
        step("R9", 0, 0, 1, 3, 1, 1);
        // R6: load 7 against head 7 in its removal cycle
        step("R6", 1, 11, 1, 7, 1, 1);
        step("R9", 0, 0, 1, 7, 1, 0);
        step("R4", 1, 12, 1, 3, 0, 0);
        step("R6", 0, 0, 1, 3, 1, 1);
        step("R4", 0, 0, 1, 3, 1, 0);

        // mixed traffic over a narrow address range
        for (int c = 0; c < 4000; c++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            step("R4", rng[0] | rng[1], AW'(rng[3:2]), rng[4] | rng[5], AW'(rng[7:6]),
                 rng[8] | rng[9], rng[10] & rng[11]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule